// File: doc/BRIEF.md
# Masked Input Change Detector with Output Control Registers

This block is a byte-wide bus slave on a Wishbone-style interface. It holds the registers that drive a set of board outputs: a relay byte, an open-collector byte and a 48-bit crosspoint control word assembled from six bytes. It also holds a mask that selects which bits of an 8-bit sense bus are watched.

The sense bus is ANDed with the mask and registered once. The result is the status byte. It goes out on a dedicated port for a downstream sequencer, and every bus read returns it, whatever the address. When the registered masked value differs from its previous value, the block raises a one-clock start pulse. The sequencer uses that pulse to begin reporting the new status.

Synchronisers for the asynchronous sense pins and the pad drivers belong to the surrounding logic.

Top module: `iwr_ctl_watch`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, wb_ack_o, kick_o, status_o, relay_o, opencoll_o, xpoint_o and wb_dat_o are all zero.
- R2: When cyc and stb are sampled high while wb_ack_o is low, wb_ack_o is high for exactly one cycle after that edge. This holds for reads and for writes.
- R3: A write to byte address 0x40 loads the mask, 0x41 loads relay_o, and 0x42 loads opencoll_o. A write to 0x43+k (k = 0..5) loads xpoint_o[8k+7:8k]. Each write takes effect at the same edge that raises wb_ack_o.
- R4: A write to an address below 0x40 or above 0x48 is acknowledged, and leaves every register output and the status unchanged.
- R5: A read at any address returns status_o on wb_dat_o while wb_ack_o is high.
- R6: status_o equals (sense_i AND mask) as sampled at the previous clock edge. A mask bit of 0 forces the matching status bit to 0.
- R7: When status_o takes a new value, kick_o is high in that same cycle, for one cycle only. While status_o holds its value, kick_o stays low.
- R8: A change on a sense_i bit whose mask bit is 0 neither raises kick_o nor alters status_o.
- R9: A mask write that changes the masked value updates status_o and raises kick_o one cycle after the write is acknowledged.
- R10: Releasing reset with sense_i nonzero raises no kick_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_adr_i | input | 8 | Byte address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data (always the status byte) |
| wb_we_i | input | 1 | Write enable |
| wb_stb_i | input | 1 | Strobe |
| wb_cyc_i | input | 1 | Cycle valid |
| wb_ack_o | output | 1 | Acknowledge, one cycle |
| sense_i | input | 8 | Watched input bus (already synchronised) |
| kick_o | output | 1 | One-clock start pulse on status change |
| status_o | output | 8 | Registered masked status |
| relay_o | output | 8 | Relay control byte |
| opencoll_o | output | 8 | Open-collector control byte |
| xpoint_o | output | 48 | Crosspoint control word |

## Verification
Each register byte can be seen directly at its output port. A write decoded to the wrong slot therefore shows up as a wrong byte on relay_o, opencoll_o or xpoint_o one cycle after the write is presented. A wrong mask or a stale delay register shows up as a wrong wb_dat_o or status_o value in the cycle after the sense bus moves. A broken comparison shows up as a missing, doubled or spurious kick_o pulse in that same cycle. Pulses are therefore checked cycle by cycle around every sense change and every mask write, including changes confined to masked-off bits.

// File: rtl/iwr_pkg.sv
package iwr_pkg;

   // Register slots in address order above the base address.
   // The crosspoint bytes follow the fixed slots, least significant first.
   localparam int unsigned IWR_FIXED_REGS = 3;
   localparam int unsigned IWR_SLOT_MASK  = 0;
   localparam int unsigned IWR_SLOT_RELAY = 1;
   localparam int unsigned IWR_SLOT_OPEN  = 2;
   localparam int unsigned IWR_SLOT_XP0   = 3;

endpackage

// File: rtl/iwr_wb_port.sv
module iwr_wb_port (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_i,
   input  logic stb_i,
   input  logic we_i,
   output logic ack_o,
   output logic wr_fire_o
);

   logic ack_q;
   logic req_new;

   // A request is new while no acknowledge is already pending.
   assign req_new   = cyc_i && stb_i && !ack_q;
   assign wr_fire_o = req_new && we_i;
   assign ack_o     = ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_new;
   end

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |=> !ack_o);                                   // R2
   AST_ACK_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> $past(cyc_i && stb_i));                     // R2
   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_i && stb_i && !ack_o) |=> ack_o);                // R2

endmodule

// File: rtl/iwr_regfile.sv
module iwr_regfile
   import iwr_pkg::*;
#(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 8,
   parameter int unsigned XP_BYTES = 6,
   parameter int unsigned BASE     = 'h40
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_fire_i,
   input  logic [AW-1:0]          wr_adr_i,
   input  logic [DW-1:0]          wr_dat_i,
   output logic [DW-1:0]          mask_o,
   output logic [DW-1:0]          relay_o,
   output logic [DW-1:0]          open_o,
   output logic [XP_BYTES*DW-1:0] xp_o
);

   localparam int unsigned NREG = IWR_FIXED_REGS + XP_BYTES;
   localparam logic [AW-1:0] BASE_A = AW'(BASE);
   localparam logic [AW-1:0] NREG_A = AW'(NREG);

   initial begin
      assert (XP_BYTES >= 1) else $error("iwr_regfile: XP_BYTES must be at least 1");
      assert (DW >= 1)       else $error("iwr_regfile: DW must be at least 1");
      assert (BASE + NREG <= (1 << AW))
         else $error("iwr_regfile: register window exceeds address space");
   end

   logic [NREG-1:0][DW-1:0] bank_q;
   logic [AW-1:0]           offset;
   logic                    hit;

   assign offset = wr_adr_i - BASE_A;
   assign hit    = (wr_adr_i >= BASE_A) && (offset < NREG_A);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (wr_fire_i && hit && (offset == AW'(i))) bank_q[i] <= wr_dat_i;
         end
      end
   end

   assign mask_o  = bank_q[IWR_SLOT_MASK];
   assign relay_o = bank_q[IWR_SLOT_RELAY];
   assign open_o  = bank_q[IWR_SLOT_OPEN];

   for (genvar j = 0; j < XP_BYTES; j++) begin : g_xp
      assign xp_o[j*DW +: DW] = bank_q[IWR_SLOT_XP0 + j];
   end

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_fire_i |=> $stable(bank_q));                      // R4
   AST_HOLD_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire_i && !hit) |=> $stable(bank_q));             // R4
   AST_MASK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fire_i && wr_adr_i == BASE_A) |=> (mask_o == $past(wr_dat_i))); // R3

endmodule

// File: rtl/iwr_change_det.sv
module iwr_change_det #(
   parameter int unsigned DW       = 8,
   parameter bit          REG_KICK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] sense_i,
   input  logic [DW-1:0] mask_i,
   output logic [DW-1:0] status_o,
   output logic          kick_o
);

   logic [DW-1:0] masked;
   logic [DW-1:0] cur_q;
   logic [DW-1:0] delta;

   assign masked = sense_i & mask_i;
   assign delta  = masked ^ cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= masked;
   end

   assign status_o = cur_q;

   if (REG_KICK) begin : g_kick_reg
      // The pulse is registered and lines up with the new status value.
      logic kick_q;
      always_ff @(posedge clk) begin
         if (!rst_n) kick_q <= 1'b0;
         else        kick_q <= |delta;
      end
      assign kick_o = kick_q;

      AST_KICK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         kick_o == (status_o != $past(status_o)));          // R7
   end else begin : g_kick_comb
      // The pulse leads the status update by one cycle.
      assign kick_o = |delta;

      AST_KICK_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
         kick_o |=> (status_o != $past(status_o)));         // R7
   end

   AST_STATUS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o & ~$past(mask_i)) == '0);                   // R6

endmodule

// File: rtl/iwr_ctl_watch.sv
module iwr_ctl_watch #(
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 8,
   parameter int unsigned XP_BYTES = 6,
   parameter int unsigned BASE     = 'h40,
   parameter bit          REG_KICK = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [AW-1:0]          wb_adr_i,
   input  logic [DW-1:0]          wb_dat_i,
   output logic [DW-1:0]          wb_dat_o,
   input  logic                   wb_we_i,
   input  logic                   wb_stb_i,
   input  logic                   wb_cyc_i,
   output logic                   wb_ack_o,
   input  logic [DW-1:0]          sense_i,
   output logic                   kick_o,
   output logic [DW-1:0]          status_o,
   output logic [DW-1:0]          relay_o,
   output logic [DW-1:0]          opencoll_o,
   output logic [XP_BYTES*DW-1:0] xpoint_o
);

   initial begin
      assert (AW >= 2) else $error("iwr_ctl_watch: AW too small");
   end

   logic          wr_fire;
   logic [DW-1:0] mask_w;

   iwr_wb_port u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_i     (wb_cyc_i),
      .stb_i     (wb_stb_i),
      .we_i      (wb_we_i),
      .ack_o     (wb_ack_o),
      .wr_fire_o (wr_fire)
   );

   iwr_regfile #(
      .DW       (DW),
      .AW       (AW),
      .XP_BYTES (XP_BYTES),
      .BASE     (BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_fire_i (wr_fire),
      .wr_adr_i  (wb_adr_i),
      .wr_dat_i  (wb_dat_i),
      .mask_o    (mask_w),
      .relay_o   (relay_o),
      .open_o    (opencoll_o),
      .xp_o      (xpoint_o)
   );

   iwr_change_det #(
      .DW       (DW),
      .REG_KICK (REG_KICK)
   ) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .sense_i  (sense_i),
      .mask_i   (mask_w),
      .status_o (status_o),
      .kick_o   (kick_o)
   );

   // Reads ignore the address.
   assign wb_dat_o = status_o;

   AST_READ_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_ack_o && !wb_we_i) |-> (wb_dat_o == status_o));   // R5

endmodule

// File: tb/tb_iwr_ctl_watch.sv
module tb_iwr_ctl_watch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  wb_adr_i = '0;
   logic [7:0]  wb_dat_i = '0;
   logic [7:0]  wb_dat_o;
   logic        wb_we_i = 1'b0;
   logic        wb_stb_i = 1'b0;
   logic        wb_cyc_i = 1'b0;
   logic        wb_ack_o;
   logic [7:0]  sense_i = '0;
   logic        kick_o;
   logic [7:0]  status_o;
   logic [7:0]  relay_o;
   logic [7:0]  opencoll_o;
   logic [47:0] xpoint_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [7:0]  exp_relay = '0;
   logic [7:0]  exp_open  = '0;
   logic [47:0] exp_xp    = '0;

   always #10 clk = ~clk;

   iwr_ctl_watch dut (
      .clk(clk), .rst_n(rst_n), .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i),
      .wb_dat_o(wb_dat_o), .wb_we_i(wb_we_i), .wb_stb_i(wb_stb_i),
      .wb_cyc_i(wb_cyc_i), .wb_ack_o(wb_ack_o), .sense_i(sense_i),
      .kick_o(kick_o), .status_o(status_o), .relay_o(relay_o),
      .opencoll_o(opencoll_o), .xpoint_o(xpoint_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Returns at the negedge one cycle after ack; ack is checked on both sides.
   task automatic wb_write(input logic [7:0] adr, input logic [7:0] dat);
      @(negedge clk);
      wb_adr_i = adr; wb_dat_i = dat; wb_we_i = 1'b1;
      wb_cyc_i = 1'b1; wb_stb_i = 1'b1;
      @(negedge clk);
      chk("R2 write ack high", wb_ack_o, 1);
      wb_cyc_i = 1'b0; wb_stb_i = 1'b0; wb_we_i = 1'b0;
      @(negedge clk);
      chk("R2 write ack one cycle", wb_ack_o, 0);
   endtask

   task automatic wb_read(input logic [7:0] adr, output logic [7:0] dat);
      @(negedge clk);
      wb_adr_i = adr; wb_we_i = 1'b0; wb_cyc_i = 1'b1; wb_stb_i = 1'b1;
      @(negedge clk);
      chk("R2 read ack high", wb_ack_o, 1);
      dat = wb_dat_o;
      wb_cyc_i = 1'b0; wb_stb_i = 1'b0;
      @(negedge clk);
      chk("R2 read ack one cycle", wb_ack_o, 0);
   endtask

   task automatic chk_outputs(input string tag);
      chk({tag, " relay"}, relay_o, exp_relay);
      chk({tag, " opencoll"}, opencoll_o, exp_open);
      chk({tag, " xpoint"}, xpoint_o, exp_xp);
   endtask

   task automatic t_reset;
      sense_i = 8'hA5;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 ack in reset", wb_ack_o, 0);
      chk("R1 kick in reset", kick_o, 0);
      chk("R1 status in reset", status_o, 0);
      chk("R1 dat_o in reset", wb_dat_o, 0);
      chk_outputs("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 status after release", status_o, 0);
      for (int i = 0; i < 4; i++) begin
         chk("R10 no kick after release", kick_o, 0);
         @(negedge clk);
      end
   endtask

   task automatic t_write_map;
      wb_write(8'h41, 8'h3C); exp_relay = 8'h3C;
      chk_outputs("R3 relay write");
      wb_write(8'h42, 8'hC3); exp_open = 8'hC3;
      chk_outputs("R3 opencoll write");
      for (int k = 0; k < 6; k++) begin
         logic [7:0] v;
         v = 8'h11 * (k + 1);
         wb_write(8'h43 + 8'(k), v);
         exp_xp[k*8 +: 8] = v;
         chk_outputs("R3 crosspoint byte write");
      end
      // Mask write: sense A5 & F0 = A0, pulse one cycle after ack.
      wb_write(8'h40, 8'hF0);
      chk("R9 kick after mask write", kick_o, 1);
      chk("R3 R6 status after mask write", status_o, 8'hA0);
      @(negedge clk);
      chk("R7 kick single cycle", kick_o, 0);
   endtask

   task automatic t_read_any;
      logic [7:0] d;
      wb_read(8'h00, d); chk("R5 read addr 00", d, 8'hA0);
      wb_read(8'h41, d); chk("R5 read addr 41", d, 8'hA0);
      wb_read(8'hFF, d); chk("R5 read addr FF", d, 8'hA0);
   endtask

   task automatic t_stray;
      wb_write(8'h3F, 8'hFF);
      chk_outputs("R4 write 3F");
      chk("R4 status after 3F", status_o, 8'hA0);
      wb_write(8'h49, 8'hFF);
      chk_outputs("R4 write 49");
      wb_write(8'hFF, 8'h00);
      chk_outputs("R4 write FF");
      chk("R4 no kick on stray", kick_o, 0);
      chk("R4 status unchanged", status_o, 8'hA0);
   endtask

   task automatic t_change;
      @(negedge clk);
      sense_i = 8'h5A;
      @(negedge clk);
      chk("R7 kick on change", kick_o, 1);
      chk("R6 status delayed masked", status_o, 8'h50);
      @(negedge clk);
      chk("R7 kick drops", kick_o, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R7 no kick while stable", kick_o, 0);
      end
   endtask

   task automatic t_masked_change;
      @(negedge clk);
      sense_i = 8'h5F;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R8 no kick on masked bit", kick_o, 0);
         chk("R8 status unaffected", status_o, 8'h50);
      end
      wb_write(8'h40, 8'hFF);
      chk("R9 kick on unmask", kick_o, 1);
      chk("R9 status after unmask", status_o, 8'h5F);
      @(negedge clk);
      chk("R9 kick single", kick_o, 0);
      chk_outputs("R3 outputs kept");
   endtask

   initial begin
      t_reset();
      t_write_map();
      t_read_any();
      t_stray();
      t_change();
      t_masked_change();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule